// File: doc/BRIEF.md
# Multi-Channel Conversion Trigger Sequencer

This block is the digital sequencer for an eight-channel analog-to-digital converter. Every channel has its own start-trigger line, driven by an external pin or a timer compare event. The block picks one channel among triggers that arrive in the same cycle. It then times a conversion whose length is programmable. When the conversion ends, it stores the value from the behavioural converter model in that channel's result register.

A small trigger counter tracks accepted triggers. When a conversion completes and the count equals the programmed target, the block emits a one-cycle interrupt and clears the counter. A new trigger aborts a conversion in flight and restarts it. Clearing the enable bit abandons the conversion. Low-power modes either let conversion run (halt) or freeze it (idle, stop). A conversion that was frozen part way is marked undefined when it later completes. Software uses a simple write/read register port.

Top module: `adc_trig_seq`

## Requirements
- R1: After reset every result register reads zero with its valid flag clear, the trigger count is 0, `busy` is low and `irq` is low.
- R2: Conversion-time code n (0..7) gives a conversion of (n+1)*16 clock cycles. The result is written and `busy` falls on the (n+1)*16-th rising edge after the edge that accepted the trigger, with the valid flag set and the data taken from `conv_data` at that edge.
- R3: If several trigger lines are high in one cycle, only the lowest-numbered channel is converted, and the count rises by exactly one. The status register reports the active channel in bits [3:1] and busy in bit 0.
- R4: A trigger that arrives during a conversion aborts it and starts a fresh full-length conversion for the new channel. The aborted channel's result register is left unchanged, but its trigger stays counted.
- R5: Writing 0 to the enable bit (address 0, bit 0) during a conversion stops it on that edge, and no result register changes. While the block is disabled, triggers are ignored and not counted.
- R6: At a completing conversion, if the 3-bit count equals the 3-bit target, `irq` is high for exactly one cycle after that edge and the count returns to 0. Otherwise `irq` stays low. The count wraps modulo 8.
- R7: Halt mode (`pwr_mode`=1) does not affect conversion timing or results. Configuration registers keep their values across any power mode.
- R8: In idle (2) or stop (3) mode, triggers are ignored and a running conversion is frozen for as long as the mode lasts. On return to run it finishes its remaining cycles and stores the data with the valid flag clear.
- R9: Register map: address 1 holds the conversion-time code in bits [2:0] and the target in bits [5:3]. Addresses 2+ch hold {valid in bit 10, data in [9:0]}. Address 10 holds the count in bits [2:0], and address 11 holds the status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address for both write and read |
| reg_wdata | input | 6 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational from reg_addr) |
| trig_in | input | 8 | Per-channel start triggers, one cycle pulse each |
| pwr_mode | input | 2 | 0 run, 1 halt, 2 idle, 3 stop |
| conv_data | input | 10 | Converted value from the behavioural model |
| busy | output | 1 | Conversion in progress |
| irq | output | 1 | One-cycle completion interrupt |

## Verification
The properties assume that trigger lines are synchronous single-cycle pulses. They also assume `pwr_mode` changes only between clock edges, and that the conversion-time code is not rewritten while a conversion runs. The stimulus keeps to these rules. Configuration is written only while the block is idle. Triggers and mode changes are driven at the falling edge. Retriggers are placed well inside a conversion, so a completion never coincides with a new acceptance. Random trigger masks are always nonzero and are applied one conversion at a time.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [1:0] {
    PM_RUN  = 2'd0,
    PM_HALT = 2'd1,
    PM_IDLE = 2'd2,
    PM_STOP = 2'd3
  } pwr_mode_e;

  localparam logic [3:0] A_CTRL = 4'd0;
  localparam logic [3:0] A_CFG  = 4'd1;
  localparam logic [3:0] A_RES0 = 4'd2;
  localparam logic [3:0] A_CNT  = 4'd10;
  localparam logic [3:0] A_STAT = 4'd11;

  // Conversion length in clock cycles for a time-select code.
  function automatic int unsigned conv_cycles(input int unsigned code,
                                              input int unsigned step);
    return (code + 1) * step;
  endfunction

  // Idle and stop both freeze the converter clock.
  function automatic logic clk_frozen(input logic [1:0] mode);
    return (mode == PM_IDLE) || (mode == PM_STOP);
  endfunction

endpackage

// File: rtl/trig_arbiter.sv
module trig_arbiter #(
  parameter int NCH = 8,
  localparam int CHW = $clog2(NCH)
) (
  input  logic [NCH-1:0] req,
  output logic [NCH-1:0] grant,
  output logic [CHW-1:0] idx,
  output logic           any
);

  for (genvar i = 0; i < NCH; i++) begin : g_gnt
    if (i == 0) begin : g_first
      assign grant[i] = req[i];
    end else begin : g_rest
      assign grant[i] = req[i] & ~|req[i-1:0];
    end
  end

  always_comb begin
    idx = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (req[i]) idx = CHW'(i);
    end
  end

  assign any = |req;

endmodule

// File: rtl/conv_timer.sv
module conv_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          run,
  input  logic          clear,
  input  logic [CW-1:0] len,
  output logic          done,
  output logic [CW-1:0] cnt
);

  assign done = run && (cnt == len - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (start || clear) cnt <= '0;
    else if (run && !done)   cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/result_bank.sv
module result_bank #(
  parameter int NCH = 8,
  parameter int DW  = 10,
  localparam int CHW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [CHW-1:0] wr_ch,
  input  logic [DW-1:0]  wr_data,
  input  logic           wr_valid,
  input  logic [CHW-1:0] rd_ch,
  output logic [DW:0]    rd_word
);

  logic [DW-1:0] dat_arr [NCH];
  logic          vld_arr [NCH];

  for (genvar c = 0; c < NCH; c++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        dat_arr[c] <= '0;
        vld_arr[c] <= 1'b0;
      end else if (wr_en && wr_ch == CHW'(c)) begin
        dat_arr[c] <= wr_data;
        vld_arr[c] <= wr_valid;
      end
    end
  end

  assign rd_word = {vld_arr[rd_ch], dat_arr[rd_ch]};

endmodule

// File: rtl/adc_trig_seq.sv
module adc_trig_seq
  import adc_seq_pkg::*;
#(
  parameter int NCH  = 8,
  parameter int DW   = 10,
  parameter int TSW  = 3,
  parameter int CNTW = 3,
  parameter int STEP = 16,
  parameter int RW   = 16,
  localparam int CHW = $clog2(NCH),
  localparam int WW  = TSW + CNTW,
  localparam int CW  = $clog2(STEP * (2 ** TSW)) + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_wr,
  input  logic [3:0]      reg_addr,
  input  logic [WW-1:0]   reg_wdata,
  output logic [RW-1:0]   reg_rdata,
  input  logic [NCH-1:0]  trig_in,
  input  logic [1:0]      pwr_mode,
  input  logic [DW-1:0]   conv_data,
  output logic            busy,
  output logic            irq
);

  // Configuration and control state
  logic            en_q;
  logic [TSW-1:0]  tsel_q;
  logic [CNTW-1:0] tgt_q;
  logic [CNTW-1:0] trig_cnt_q;
  logic            busy_q;
  logic [CHW-1:0]  ch_q;
  logic            taint_q;
  logic            irq_q;

  // Named internal events (observed by the checker)
  logic            gated;
  logic            en_clr;
  logic            evt_kill;
  logic            evt_accept;
  logic            evt_store;
  logic            evt_irq;
  logic            conv_done;
  logic [NCH-1:0]  trig_live;
  logic [NCH-1:0]  grant;
  logic [CHW-1:0]  grant_idx;
  logic [CW-1:0]   conv_len;
  logic [CW-1:0]   tcnt;
  logic [CHW-1:0]  rd_ch;
  logic [DW:0]     rd_word;
  logic            rd_is_res;

  assign gated    = clk_frozen(pwr_mode);
  assign en_clr   = reg_wr && (reg_addr == A_CTRL) && !reg_wdata[0];
  assign evt_kill = en_clr && busy_q;

  assign trig_live = trig_in & {NCH{en_q && !gated && !en_clr}};

  trig_arbiter #(.NCH(NCH)) arb_i (
    .req   (trig_live),
    .grant (grant),
    .idx   (grant_idx),
    .any   (evt_accept)
  );

  assign conv_len = CW'(conv_cycles(int'(tsel_q), STEP));

  conv_timer #(.CW(CW)) tmr_i (
    .clk   (clk),
    .rst_n (rst_n),
    .start (evt_accept),
    .run   (busy_q && !gated && !evt_kill),
    .clear (evt_kill),
    .len   (conv_len),
    .done  (conv_done),
    .cnt   (tcnt)
  );

  assign evt_store = conv_done;
  assign evt_irq   = evt_store && (trig_cnt_q == tgt_q);

  result_bank #(.NCH(NCH), .DW(DW)) bank_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (evt_store),
    .wr_ch    (ch_q),
    .wr_data  (conv_data),
    .wr_valid (!taint_q),
    .rd_ch    (rd_ch),
    .rd_word  (rd_word)
  );

  // Register writes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      tsel_q <= '0;
      tgt_q  <= '0;
    end else if (reg_wr) begin
      if (reg_addr == A_CTRL) en_q <= reg_wdata[0];
      if (reg_addr == A_CFG) begin
        tsel_q <= reg_wdata[TSW-1:0];
        tgt_q  <= reg_wdata[WW-1:TSW];
      end
    end
  end

  // Conversion sequencing
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q     <= 1'b0;
      ch_q       <= '0;
      taint_q    <= 1'b0;
      trig_cnt_q <= '0;
      irq_q      <= 1'b0;
    end else begin
      irq_q      <= evt_irq;
      trig_cnt_q <= (evt_irq ? '0 : trig_cnt_q) + CNTW'(evt_accept);
      if (evt_kill) begin
        busy_q  <= 1'b0;
        taint_q <= 1'b0;
      end else if (evt_accept) begin
        busy_q  <= 1'b1;
        ch_q    <= grant_idx;
        taint_q <= 1'b0;
      end else if (evt_store) begin
        busy_q  <= 1'b0;
      end else if (gated && busy_q) begin
        taint_q <= 1'b1;
      end
    end
  end

  // Register reads
  assign rd_is_res = (reg_addr >= A_RES0) && (reg_addr < A_RES0 + 4'(NCH));
  assign rd_ch     = CHW'(reg_addr - A_RES0);

  always_comb begin
    reg_rdata = '0;
    if (rd_is_res)                reg_rdata = RW'(rd_word);
    else if (reg_addr == A_CTRL)  reg_rdata = RW'(en_q);
    else if (reg_addr == A_CFG)   reg_rdata = RW'({tgt_q, tsel_q});
    else if (reg_addr == A_CNT)   reg_rdata = RW'(trig_cnt_q);
    else if (reg_addr == A_STAT)  reg_rdata = RW'({ch_q, busy_q});
  end

  assign busy = busy_q;
  assign irq  = irq_q;

endmodule

// File: rtl/adc_trig_seq_chk.sv
module adc_trig_seq_chk #(
  parameter int NCH = 8,
  parameter int CW  = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           en_q,
  input logic           gated,
  input logic [NCH-1:0] trig_in,
  input logic [NCH-1:0] grant,
  input logic           evt_accept,
  input logic           evt_store,
  input logic           evt_kill,
  input logic           busy_q,
  input logic           irq_q,
  input logic [CW-1:0]  tcnt
);

  // R3
  lowest_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_accept |-> ($onehot(grant) && ((grant & trig_in) == grant)
                    && ((trig_in & (grant - 1'b1)) == '0)));

  // R5
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> (!evt_store && !busy_q));

  // R6
  irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |=> !irq_q);

  // R8
  frozen_events_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gated |-> (!evt_accept && !evt_store));

  // R8
  frozen_timer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gated && busy_q && !evt_kill) |=> $stable(tcnt));

  // R2
  store_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_store |-> busy_q);

  // R4
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_accept |=> busy_q);

endmodule

bind adc_trig_seq adc_trig_seq_chk #(.NCH(NCH), .CW(CW)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .en_q       (en_q),
  .gated      (gated),
  .trig_in    (trig_in),
  .grant      (grant),
  .evt_accept (evt_accept),
  .evt_store  (evt_store),
  .evt_kill   (evt_kill),
  .busy_q     (busy_q),
  .irq_q      (irq_q),
  .tcnt       (tcnt)
);

// File: tb/adc_trig_seq_tb_top.sv
module adc_trig_seq_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [3:0]  reg_addr;
  logic [5:0]  reg_wdata;
  logic [15:0] reg_rdata;
  logic [7:0]  trig_in;
  logic [1:0]  pwr_mode;
  logic [9:0]  conv_data;
  logic        busy;
  logic        irq;

  always #5 clk = ~clk;

  adc_trig_seq dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .trig_in   (trig_in),
    .pwr_mode  (pwr_mode),
    .conv_data (conv_data),
    .busy      (busy),
    .irq       (irq)
  );

  int   n_chk = 0;
  int   n_fail = 0;
  bit   finished = 1'b0;
  int   exp_cnt = 0;
  int   tgt = 0;
  int   tsel = 0;
  logic [9:0] ev [8];
  logic       evld [8];

  function automatic int lenof(int code);
    return (code + 1) * 16;
  endfunction

  function automatic int lowest(logic [7:0] m);
    for (int i = 0; i < 8; i++) if (m[i]) return i;
    return -1;
  endfunction

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [5:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [15:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic cfg(int ts, int tg);
    wr(4'd1, 6'((tg << 3) | ts));
    tsel = ts; tgt = tg;
  endtask

  task automatic fire(logic [7:0] m, bit counted);
    @(negedge clk);
    trig_in = m;
    @(posedge clk);
    @(negedge clk);
    trig_in = '0;
    if (counted) exp_cnt = (exp_cnt + 1) % 8;
  endtask

  task automatic check_res(int ch, string r);
    logic [15:0] x;
    rd(4'(2 + ch), x);
    chk(r, 32'(x), 32'({evld[ch], ev[ch]}));
  endtask

  task automatic wait_done(int ch, logic [9:0] d, logic v, int lw, string r);
    logic [15:0] x;
    bit ei;
    repeat (lw - 1) @(posedge clk);
    @(negedge clk);
    chk(r, 32'(busy), 1);
    @(posedge clk);
    @(negedge clk);
    chk(r, 32'(busy), 0);
    ei = (exp_cnt == tgt);
    chk("R6", 32'(irq), 32'(ei));
    if (ei) exp_cnt = 0;
    ev[ch] = d; evld[ch] = v;
    check_res(ch, r);
    rd(4'd10, x);
    chk("R6", 32'(x), 32'(exp_cnt));
    @(negedge clk);
    chk("R6", 32'(irq), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] x;
    void'($urandom(32'd5150));
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    trig_in = '0; pwr_mode = 2'd0; conv_data = '0;
    for (int i = 0; i < 8; i++) begin ev[i] = '0; evld[i] = 1'b0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int i = 0; i < 8; i++) check_res(i, "R1");
    rd(4'd10, x); chk("R1", 32'(x), 0);
    chk("R1", 32'(busy), 0);
    chk("R1", 32'(irq), 0);
    rd(4'd1, x); chk("R9", 32'(x), 0);

    wr(4'd0, 6'd1);
    cfg(0, 0);
    rd(4'd1, x); chk("R9", 32'(x), 0);

    // R2 single conversion timing
    conv_data = 10'h155;
    fire(8'h08, 1);
    wait_done(3, 10'h155, 1'b1, lenof(0), "R2");

    cfg(1, 0);
    conv_data = 10'h2a3;
    fire(8'h20, 1);
    wait_done(5, 10'h2a3, 1'b1, lenof(1), "R2");

    // R3 simultaneous triggers
    conv_data = 10'h0f1;
    cfg(0, 0);
    fire(8'hb4, 1);
    rd(4'd11, x); chk("R3", 32'(x), 32'((2 << 1) | 1));
    rd(4'd10, x); chk("R3", 32'(x), 32'(exp_cnt));
    wait_done(2, 10'h0f1, 1'b1, lenof(0), "R3");

    // R4 retrigger aborts and restarts
    conv_data = 10'h3c3;
    fire(8'h80, 1);
    repeat (4) @(negedge clk);
    fire(8'h40, 1);
    rd(4'd10, x); chk("R4", 32'(x), 32'(exp_cnt));
    rd(4'd11, x); chk("R4", 32'(x), 32'((6 << 1) | 1));
    wait_done(6, 10'h3c3, 1'b1, lenof(0), "R4");
    check_res(7, "R4");

    // R5 enable cleared mid-conversion
    conv_data = 10'h111;
    fire(8'h02, 1);
    repeat (3) @(posedge clk);
    wr(4'd0, 6'd0);
    chk("R5", 32'(busy), 0);
    check_res(1, "R5");
    fire(8'h01, 0);
    chk("R5", 32'(busy), 0);
    rd(4'd10, x); chk("R5", 32'(x), 32'(exp_cnt));
    repeat (40) @(negedge clk);
    check_res(1, "R5");
    check_res(0, "R5");
    wr(4'd0, 6'd1);

    // R6 interrupt when count meets target
    cfg(0, (exp_cnt + 1) % 8);
    conv_data = 10'h2f0;
    fire(8'h10, 1);
    wait_done(4, 10'h2f0, 1'b1, lenof(0), "R6");

    // R7 halt mode keeps running
    cfg(2, 7);
    conv_data = 10'h099;
    fire(8'h01, 1);
    repeat (2) @(posedge clk);
    @(negedge clk);
    pwr_mode = 2'd1;
    wait_done(0, 10'h099, 1'b1, lenof(2) - 2, "R7");
    pwr_mode = 2'd0;
    rd(4'd1, x); chk("R7", 32'(x), 32'((7 << 3) | 2));

    // R8 idle mode freezes and taints the result
    cfg(0, 7);
    conv_data = 10'h377;
    fire(8'h10, 1);
    repeat (3) @(posedge clk);
    @(negedge clk);
    pwr_mode = 2'd2;
    repeat (5) @(posedge clk);
    fire(8'h01, 0);
    chk("R8", 32'(busy), 1);
    rd(4'd11, x); chk("R8", 32'(x), 32'((4 << 1) | 1));
    rd(4'd10, x); chk("R8", 32'(x), 32'(exp_cnt));
    repeat (14) @(posedge clk);
    @(negedge clk);
    pwr_mode = 2'd0;
    wait_done(4, 10'h377, 1'b0, lenof(0) - 3, "R8");
    rd(4'd1, x); chk("R7", 32'(x), 32'(7 << 3));

    // R8 stop mode ignores triggers
    pwr_mode = 2'd3;
    fire(8'h04, 0);
    chk("R8", 32'(busy), 0);
    rd(4'd10, x); chk("R8", 32'(x), 32'(exp_cnt));
    pwr_mode = 2'd0;

    // Random conversions: R2, R3, R6
    for (int it = 0; it < 25; it++) begin
      int ts;
      int tg;
      logic [7:0] m;
      logic [9:0] d;
      ts = int'($urandom % 3);
      tg = int'($urandom % 8);
      m  = 8'(($urandom % 255) + 1);
      d  = 10'($urandom);
      cfg(ts, tg);
      conv_data = d;
      fire(m, 1);
      wait_done(lowest(m), d, 1'b1, lenof(ts), "R3");
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule